// File: doc/BRIEF.md
# UART Transceiver with Status Flag Byte

This block is a full-duplex asynchronous serial transceiver that reports its condition through one 8-bit status byte. The transmitter takes a byte (and an optional ninth bit) on a write strobe, frames it with a start bit, an optional parity bit and one or two stop bits, and shifts it out LSB first. A one-entry holding register lets software queue a second frame while the first is still on the line. The receiver oversamples the serial input at 16 ticks per bit and rejects glitches that do not last to mid-bit. It places each completed frame into a single receive buffer.

The status byte shows whether each direction is busy, carries the ninth received data bit, and holds the parity, framing and overrun errors. The error flags clear when the receive buffer is read. Each direction produces a one-cycle end-of-frame pulse. Baud-rate generation is external: the block is driven by a tick at 16 times the bit rate. Frame format is selected by static configuration inputs.

Top module: `uart_stat`

## Requirements
- R1: After reset, the status byte reads 00h, the serial output is high and the receive buffer reads 00h. Status layout: bit 7 transmit busy, bit 6 receive busy, bit 4 ninth received bit, bit 2 parity error, bit 1 framing error, bit 0 overrun. Bits 5 and 3 always read 0.
- R2: Transmit busy (bit 7) reads 1 in the cycle after a transmit write. It clears in the same cycle as the transmit-end pulse of the last queued frame.
- R3: If a second write arrives while a frame is being sent, both frames go out back to back. Transmit-end pulses once per frame. Transmit busy is still 1 at the first pulse and is 0 at the second.
- R4: A transmitted frame consists of, in order: a low start bit, 8 data bits LSB first, the transmit-extension bit if 9-bit format is on, a parity bit if parity is on, and one or two high stop bits. Each bit lasts 16 ticks. The parity mode input encodes 00 none, 01 zero (a 0 is sent), 10 odd and 11 even. Odd and even parity count the data bits and the extension bit.
- R5: Receive busy (bit 6) is 1 from the confirmed start bit through the data bits. It clears in the same cycle as the receive-end pulse, which occurs when the stop bit is sampled.
- R6: A low level on the serial input that ends before mid-bit is ignored: receive busy stays 0 and no receive-end pulse occurs.
- R7: A received byte appears on the receive-data output at the receive-end pulse. In 9-bit format the ninth received bit appears in status bit 4. In 8-bit format status bit 4 is 0.
- R8: In odd or even mode, status bit 2 sets when the parity of the received data plus the received parity bit does not match the mode. In none or zero mode, bit 2 never sets.
- R9: Status bit 1 sets when the first stop bit is sampled low.
- R10: If a frame completes while the previous one is still unread, status bit 0 sets and the buffer holds the newer frame.
- R11: A receive-buffer read strobe clears status bits 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line |
| txWr | input | 1 | Transmit write strobe |
| txData | input | 8 | Byte to transmit |
| txExt | input | 1 | Ninth transmit bit, used in 9-bit format |
| rxRd | input | 1 | Receive buffer read strobe |
| parMode | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| twoStop | input | 1 | 1 selects two transmit stop bits |
| nineBit | input | 1 | 1 selects 9-bit extended format |
| txd | output | 1 | Serial output line |
| rxData | output | 8 | Receive buffer contents |
| status | output | 8 | Status byte |
| txEndIrq | output | 1 | One-cycle pulse at the end of each transmitted frame |
| rxEndIrq | output | 1 | One-cycle pulse at each received stop bit |

## Verification
Two cases are the hardest to reach from the ports. The first is the busy flag during two-frame continuous transmission. The bench watches for the falling start edge of the first frame, issues the second write while that frame is in flight, and records the busy bit at each of the two end pulses. The second is a false start that must not be mistaken for a framing error. The bench drives a low pulse of a quarter bit. For the framing test it releases the low stop bit shortly after its midpoint, so that the receiver resynchronises on idle and does not treat the tail of the stop bit as a new start bit.

// File: rtl/uart_stat_pkg.sv
`timescale 1ns/1ps
package uart_stat_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } parMode_e;

  // strobes from receive control to receive datapath
  typedef struct packed {
    logic startOk;
    logic shiftEn;
    logic parSample;
    logic stopSample;
    logic bitVal;
  } rxStrobe_t;
endpackage

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txExt,
  input  parMode_e          parMode,
  input  logic              twoStop,
  input  logic              nineBit,
  output logic              txd,
  output logic              txBusy,
  output logic              txEndIrq
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int SUB_W   = $clog2(OVS);

  logic [DATA_W-1:0]  holdData;
  logic               holdExt, holdValid, active;
  logic [FRAME_W-1:0] shiftR, nextFrame;
  logic [CNT_W-1:0]   bitsLeft, nextLen, pos;
  logic [SUB_W-1:0]   subCnt;
  logic               ones, parBit;

  always_comb begin
    nextFrame = '1;
    nextFrame[0] = 1'b0;
    nextFrame[DATA_W:1] = holdData;
    pos = CNT_W'(DATA_W + 1);
    if (nineBit) begin
      nextFrame[pos] = holdExt;
      pos = pos + CNT_W'(1);
    end
    ones = (^holdData) ^ (nineBit & holdExt);
    unique case (parMode)
      PAR_ODD:  parBit = ~ones;
      PAR_EVEN: parBit = ones;
      default:  parBit = 1'b0;
    endcase
    if (parMode != PAR_NONE) begin
      nextFrame[pos] = parBit;
      pos = pos + CNT_W'(1);
    end
    nextLen = pos + CNT_W'(1) + {{(CNT_W-1){1'b0}}, twoStop};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdExt   <= 1'b0;
      holdValid <= 1'b0;
      active    <= 1'b0;
      shiftR    <= '1;
      bitsLeft  <= '0;
      subCnt    <= '0;
      txEndIrq  <= 1'b0;
    end else begin
      txEndIrq <= 1'b0;
      if (!active) begin
        if (holdValid) begin
          shiftR    <= nextFrame;
          bitsLeft  <= nextLen;
          subCnt    <= '0;
          active    <= 1'b1;
          holdValid <= 1'b0;
        end
      end else if (baudTick) begin
        if (subCnt == SUB_W'(OVS - 1)) begin
          subCnt   <= '0;
          shiftR   <= {1'b1, shiftR[FRAME_W-1:1]};
          bitsLeft <= bitsLeft - CNT_W'(1);
          if (bitsLeft == CNT_W'(1)) begin
            active   <= 1'b0;
            txEndIrq <= 1'b1;
          end
        end else begin
          subCnt <= subCnt + SUB_W'(1);
        end
      end
      if (txWr) begin
        holdData  <= txData;
        holdExt   <= txExt;
        holdValid <= 1'b1;
      end
    end
  end

  assign txd    = active ? shiftR[0] : 1'b1;
  assign txBusy = active | holdValid;

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> txEndIrq);
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> txd);
endmodule

// File: rtl/uart_rx_ctrl.sv
`timescale 1ns/1ps
module uart_rx_ctrl
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxd,
  input  parMode_e  parMode,
  input  logic      nineBit,
  output rxStrobe_t strobe,
  output logic      rxBusy,
  output logic      rxEndIrq
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 4);
  localparam int HALF  = OVS / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_RECV} rxState_e;
  rxState_e         state;
  logic             rxMeta, rxS, hasPar, sampleNow;
  logic [SUB_W-1:0] subCnt;
  logic [IDX_W-1:0] bitIdx, dataBits, stopIdx;

  always_comb begin
    hasPar    = (parMode != PAR_NONE);
    dataBits  = IDX_W'(DATA_W) + {{(IDX_W-1){1'b0}}, nineBit};
    stopIdx   = dataBits + {{(IDX_W-1){1'b0}}, hasPar};
    sampleNow = baudTick && (state == ST_RECV) && (subCnt == SUB_W'(OVS - 1));
    strobe.startOk    = baudTick && (state == ST_START) &&
                        (subCnt == SUB_W'(HALF - 1)) && !rxS;
    strobe.shiftEn    = sampleNow && (bitIdx < dataBits);
    strobe.parSample  = sampleNow && hasPar && (bitIdx == dataBits);
    strobe.stopSample = sampleNow && (bitIdx == stopIdx);
    strobe.bitVal     = rxS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxS      <= 1'b1;
      state    <= ST_IDLE;
      subCnt   <= '0;
      bitIdx   <= '0;
      rxBusy   <= 1'b0;
      rxEndIrq <= 1'b0;
    end else begin
      rxMeta   <= rxd;
      rxS      <= rxMeta;
      rxEndIrq <= 1'b0;
      if (baudTick) begin
        unique case (state)
          ST_IDLE: if (!rxS) begin
            state  <= ST_START;
            subCnt <= '0;
          end
          ST_START: if (subCnt == SUB_W'(HALF - 1)) begin
            subCnt <= '0;
            bitIdx <= '0;
            if (!rxS) begin
              state  <= ST_RECV;
              rxBusy <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            subCnt <= subCnt + SUB_W'(1);
          end
          ST_RECV: if (subCnt == SUB_W'(OVS - 1)) begin
            subCnt <= '0;
            if (bitIdx == stopIdx) begin
              state    <= ST_IDLE;
              rxBusy   <= 1'b0;
              rxEndIrq <= 1'b1;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            subCnt <= subCnt + SUB_W'(1);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  rx_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxBusy) |-> rxEndIrq);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startOk |=> rxBusy);
endmodule

// File: rtl/uart_rx_dp.sv
`timescale 1ns/1ps
module uart_rx_dp
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  parMode_e          parMode,
  input  logic              nineBit,
  input  logic              rxRd,
  output logic [DATA_W-1:0] rxData,
  output logic              ninth,
  output logic              parErr,
  output logic              frameErr,
  output logic              overErr
);
  logic [DATA_W:0] shiftR;
  logic            parBad, bufFull, sumOdd;

  assign sumOdd = (^shiftR) ^ strobe.bitVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftR   <= '0;
      parBad   <= 1'b0;
      bufFull  <= 1'b0;
      rxData   <= '0;
      ninth    <= 1'b0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
      overErr  <= 1'b0;
    end else begin
      if (strobe.startOk) begin
        shiftR <= '0;
        parBad <= 1'b0;
      end
      if (strobe.shiftEn) shiftR <= {strobe.bitVal, shiftR[DATA_W:1]};
      if (strobe.parSample)
        parBad <= (parMode == PAR_ODD)  ? ~sumOdd :
                  (parMode == PAR_EVEN) ?  sumOdd : 1'b0;
      if (rxRd) begin
        parErr   <= 1'b0;
        frameErr <= 1'b0;
        overErr  <= 1'b0;
        bufFull  <= 1'b0;
      end
      if (strobe.stopSample) begin
        rxData   <= nineBit ? shiftR[DATA_W-1:0] : shiftR[DATA_W:1];
        ninth    <= nineBit & shiftR[DATA_W];
        parErr   <= parBad & parMode[1];
        frameErr <= ~strobe.bitVal;
        overErr  <= bufFull & ~rxRd;
        bufFull  <= 1'b1;
      end
    end
  end

  // R11
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && !strobe.stopSample) |=> (!parErr && !frameErr && !overErr));
  // R8
  no_par_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopSample && !parMode[1]) |=> !parErr);
endmodule

// File: rtl/uart_stat.sv
`timescale 1ns/1ps
module uart_stat
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxd,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txExt,
  input  logic              rxRd,
  input  logic [1:0]        parMode,
  input  logic              twoStop,
  input  logic              nineBit,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        status,
  output logic              txEndIrq,
  output logic              rxEndIrq
);
  parMode_e  pm;
  rxStrobe_t strobe;
  logic      txBusy, rxBusy, ninth, parErr, frameErr, overErr;

  assign pm = parMode_e'(parMode);

  uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txWr(txWr),
    .txData(txData), .txExt(txExt), .parMode(pm), .twoStop(twoStop),
    .nineBit(nineBit), .txd(txd), .txBusy(txBusy), .txEndIrq(txEndIrq));

  uart_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_rxCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxd(rxd),
    .parMode(pm), .nineBit(nineBit), .strobe(strobe),
    .rxBusy(rxBusy), .rxEndIrq(rxEndIrq));

  uart_rx_dp #(.DATA_W(DATA_W)) u_rxDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .parMode(pm),
    .nineBit(nineBit), .rxRd(rxRd), .rxData(rxData), .ninth(ninth),
    .parErr(parErr), .frameErr(frameErr), .overErr(overErr));

  assign status = {txBusy, rxBusy, 1'b0, ninth, 1'b0, parErr, frameErr, overErr};
endmodule

// File: tb/tb_uart_stat.sv
`timescale 1ns/1ps
module tb_uart_stat;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, baudTick = 1'b0, rxd = 1'b1, txWr = 1'b0, txExt = 1'b0;
  logic       rxRd = 1'b0, twoStop = 1'b0, nineBit = 1'b0;
  logic [7:0] txData = '0;
  logic [1:0] parMode = 2'b00;
  logic       txd, txEndIrq, rxEndIrq;
  logic [7:0] rxData, status;

  int nChecks = 0, nFail = 0;
  int txEndCnt = 0, rxEndCnt = 0;
  logic lastBusyEnd = 1'b0, prevBusyEnd = 1'b0, rxBusyAtEnd = 1'b0, midBusy = 1'b0;
  int tickCnt = 0;

  uart_stat dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxd(rxd), .txWr(txWr),
    .txData(txData), .txExt(txExt), .rxRd(rxRd), .parMode(parMode),
    .twoStop(twoStop), .nineBit(nineBit), .txd(txd), .rxData(rxData),
    .status(status), .txEndIrq(txEndIrq), .rxEndIrq(rxEndIrq));

  always @(negedge clk) begin
    tickCnt  = (tickCnt + 1) % 4;
    baudTick = (tickCnt == 0);
  end

  always @(negedge clk) begin
    if (txEndIrq) begin
      txEndCnt++;
      prevBusyEnd = lastBusyEnd;
      lastBusyEnd = status[7];
    end
    if (rxEndIrq) begin
      rxEndCnt++;
      rxBusyAtEnd = status[6];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkTx(input logic [7:0] d, input logic nine,
      input logic ext, input logic [1:0] pm, input logic two, output int n);
    logic [15:0] v;
    logic ones;
    int idx;
    v = '0;
    idx = 1;
    for (int i = 0; i < 8; i++) begin v[idx] = d[i]; idx++; end
    if (nine) begin v[idx] = ext; idx++; end
    ones = (^d) ^ (nine & ext);
    if (pm != 2'b00) begin
      v[idx] = (pm == 2'b01) ? 1'b0 : (pm == 2'b10) ? ~ones : ones;
      idx++;
    end
    v[idx] = 1'b1; idx++;
    if (two) begin v[idx] = 1'b1; idx++; end
    n = idx;
    return v;
  endfunction

  task automatic writeTx(input logic [7:0] d, input logic ext);
    @(negedge clk);
    txData = d; txExt = ext; txWr = 1'b1;
    @(negedge clk);
    txWr = 1'b0;
  endtask

  task automatic captureTx(input int n, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < 2000 && txd !== 1'b0; i++) @(negedge clk);
    repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic waitTxEnd(input int target);
    for (int i = 0; i < 4000 && txEndCnt < target; i++) @(negedge clk);
  endtask

  task automatic rxFrame(input logic [7:0] d, input logic useExt, input logic ext,
                         input logic usePar, input logic parBit, input logic stopBit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (i == 4) begin
        repeat (32) @(negedge clk);
        midBusy = status[6];
        repeat (BIT_CLKS - 32) @(negedge clk);
      end else repeat (BIT_CLKS) @(negedge clk);
    end
    if (useExt) begin rxd = ext; repeat (BIT_CLKS) @(negedge clk); end
    if (usePar) begin rxd = parBit; repeat (BIT_CLKS) @(negedge clk); end
    rxd = stopBit;
    if (stopBit) repeat (BIT_CLKS) @(negedge clk);
    else repeat (48) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic readBuf();
    @(negedge clk); rxRd = 1'b1;
    @(negedge clk); rxRd = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "status after reset", 16'(status), 16'h00);
    chk("R1", "txd idle", 16'(txd), 16'h1);
    chk("R1", "rxData after reset", 16'(rxData), 16'h00);
  endtask

  task automatic testTxSingle();
    logic [15:0] exp, got;
    int n, base;
    parMode = 2'b00; twoStop = 1'b0; nineBit = 1'b0;
    base = txEndCnt;
    exp = mkTx(8'h3C, 1'b0, 1'b0, 2'b00, 1'b0, n);
    writeTx(8'h3C, 1'b0);
    chk("R2", "busy after write", 16'(status[7]), 16'h1);
    captureTx(n, got);
    chk("R4", "8N1 frame bits", got, exp);
    waitTxEnd(base + 1);
    chk("R2", "one end pulse", 16'(txEndCnt - base), 16'h1);
    chk("R2", "busy at end pulse", 16'(lastBusyEnd), 16'h0);
  endtask

  task automatic testTxFormats();
    logic [15:0] exp, got;
    int n, base;
    parMode = 2'b11; twoStop = 1'b1; nineBit = 1'b1;
    base = txEndCnt;
    exp = mkTx(8'h81, 1'b1, 1'b1, 2'b11, 1'b1, n);
    writeTx(8'h81, 1'b1);
    captureTx(n, got);
    chk("R4", "9-bit even 2-stop frame", got, exp);
    waitTxEnd(base + 1);
    parMode = 2'b01; twoStop = 1'b0; nineBit = 1'b0;
    base = txEndCnt;
    exp = mkTx(8'hFF, 1'b0, 1'b0, 2'b01, 1'b0, n);
    writeTx(8'hFF, 1'b0);
    captureTx(n, got);
    chk("R4", "zero-parity frame", got, exp);
    waitTxEnd(base + 1);
    parMode = 2'b10;
    base = txEndCnt;
    exp = mkTx(8'h07, 1'b0, 1'b0, 2'b10, 1'b0, n);
    writeTx(8'h07, 1'b0);
    captureTx(n, got);
    chk("R4", "odd-parity frame", got, exp);
    waitTxEnd(base + 1);
  endtask

  task automatic testTxBackToBack();
    int base;
    parMode = 2'b00; twoStop = 1'b0; nineBit = 1'b0;
    base = txEndCnt;
    writeTx(8'h55, 1'b0);
    for (int i = 0; i < 2000 && txd !== 1'b0; i++) @(negedge clk);
    repeat (100) @(negedge clk);
    writeTx(8'hAA, 1'b0);
    waitTxEnd(base + 2);
    chk("R3", "two end pulses", 16'(txEndCnt - base), 16'h2);
    chk("R3", "busy at first end", 16'(prevBusyEnd), 16'h1);
    chk("R3", "busy at second end", 16'(lastBusyEnd), 16'h0);
  endtask

  task automatic testRxBasic();
    int base;
    parMode = 2'b00; nineBit = 1'b0;
    base = rxEndCnt;
    rxFrame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5", "busy mid-frame", 16'(midBusy), 16'h1);
    chk("R5", "busy at rx end", 16'(rxBusyAtEnd), 16'h0);
    chk("R5", "one rx end pulse", 16'(rxEndCnt - base), 16'h1);
    chk("R7", "rxData 8-bit", 16'(rxData), 16'hA5);
    chk("R7", "status clean", 16'(status), 16'h00);
    readBuf();
  endtask

  task automatic testFalseStart();
    int base;
    logic sawBusy;
    base = rxEndCnt;
    sawBusy = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    for (int i = 0; i < 3 * BIT_CLKS; i++) begin
      @(negedge clk);
      if (status[6]) sawBusy = 1'b1;
    end
    chk("R6", "busy on glitch", 16'(sawBusy), 16'h0);
    chk("R6", "rx end on glitch", 16'(rxEndCnt - base), 16'h0);
  endtask

  task automatic testParity();
    parMode = 2'b10;
    rxFrame(8'h07, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8", "odd parity good", 16'(status[2]), 16'h0);
    readBuf();
    rxFrame(8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8", "odd parity bad", 16'(status[2]), 16'h1);
    readBuf();
    chk("R11", "read clears parity", 16'(status[2:0]), 16'h0);
    parMode = 2'b11;
    rxFrame(8'h07, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8", "even parity bad", 16'(status[2]), 16'h1);
    readBuf();
    parMode = 2'b01;
    rxFrame(8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8", "zero mode ignores parity", 16'(status[2]), 16'h0);
    chk("R8", "zero mode data", 16'(rxData), 16'h07);
    readBuf();
    parMode = 2'b00;
  endtask

  task automatic testFraming();
    rxFrame(8'h3E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "framing flag", 16'(status[1]), 16'h1);
    readBuf();
    chk("R11", "read clears framing", 16'(status[2:0]), 16'h0);
  endtask

  task automatic testOverrun();
    rxFrame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "no overrun first", 16'(status[0]), 16'h0);
    rxFrame(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "overrun flag", 16'(status[0]), 16'h1);
    chk("R10", "newest data kept", 16'(rxData), 16'h22);
    readBuf();
    chk("R11", "read clears overrun", 16'(status[2:0]), 16'h0);
  endtask

  task automatic testNinth();
    nineBit = 1'b1;
    rxFrame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7", "ninth bit set", 16'(status[4]), 16'h1);
    chk("R7", "9-bit data", 16'(rxData), 16'h5A);
    chk("R1", "reserved bits zero", 16'({status[5], status[3]}), 16'h0);
    readBuf();
    rxFrame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", "ninth bit clear", 16'(status[4]), 16'h0);
    chk("R7", "9-bit data 2", 16'(rxData), 16'hC3);
    readBuf();
    nineBit = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTxSingle();
    testTxFormats();
    testTxBackToBack();
    testRxBasic();
    testFalseStart();
    testParity();
    testFraming();
    testOverrun();
    testNinth();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule